// File: doc/BRIEF.md
# PCI Bridge Control Register Bank

This block is the software-visible control and status register bank of a host-to-PCI bridge. A simple 32-bit register bus presents one request per cycle: a strobe, a write flag, a byte address, a size code and write data. The bank checks each access against its address map and per-offset size rules. It updates the addressed register and returns registered read data, or an error pulse if the access is invalid.

The registers control several things: which of the bridge's I/O address windows forward to PCI, the fast back-to-back enables, the transfer-of-control target address, and the configuration address that goes to the configuration-cycle logic. A small interrupt group tracks level, pending, mask and control state, with derived request views. A block of thirteen bridge feature registers follows. Each of them has its own count of writable low bits, and some have bits that always read as zero. The bank drives the per-window forward enables, the cleaned configuration address and the control values straight to the neighbouring datapath logic.

Top module: `pcib_csr_bank`

## Requirements
- R1: Address map (byte offsets). I/O window enable 0x000, I/O control 0x004, fast back-to-back 0x008, TOC address 0x00C, config address 0x010, interrupt pending 0x014, interrupt mask 0x018, interrupt control 0x01C, interrupt level 0x020, interrupt request 0 at 0x024, interrupt request 1 at 0x028, PCI I/O data window 0x040 to 0x043. The thirteen feature registers sit at 0x100 + 4*i for i = 0 to 12, so 0x130 is valid and 0x134 is not. Registers need a word-aligned address. Every address outside this map is invalid.
- R2: A write to feature register i keeps only the low W(i) bits, where W = 1, 7, 7, 8, 7, 9, 0, 8, 30, 24, 22, 0, 9 for i = 0 to 12. All higher bits are stored as zero.
- R3: On read, feature register 1 returns bit 0 as zero. Feature register 7 returns bits 2:0 as zero. Feature register 8 returns as zero every bit set in 0x010710E8.
- R4: The fast back-to-back register keeps only bits 1:0 of a write. Those bits drive `fb2b_en_o`.
- R5: The TOC address register resets to 0xFFFA0030. A write stores 0xFFFA0030 OR (wdata AND 0x0001E000). The stored value drives `toc_addr_o`.
- R6: Each cycle, the interrupt level register samples `irq_lines`. Each cycle, the pending register ORs in the level register. A write of any value to the pending register clears it. Writes to the level register and to both request registers have no effect.
- R7: Interrupt request 1 reads as level AND mask AND control. Interrupt request 0 reads as pending AND mask.
- R8: The config address register reads back the whole written word. `cfg_addr_o` carries the same word with bits 1:0 cleared.
- R9: The I/O window enable register stores all 32 bits. `win_fwd_en[k-1]` is 1 exactly when I/O control bits 8:7 equal 2'b01 and enable bit k is set, for k = 1 to 30. Enable bits 0 and 31 never forward. `win_fwd_en` follows a register write by one further cycle.
- R10: Size codes are 0 = byte, 1 = halfword, 2 or 3 = word. In the data window, offset 0 accepts any size, offset 2 accepts byte or halfword, and offsets 1 and 3 accept byte only. Register offsets accept any size and always transfer the full word. Data-window reads return zero.
- R11: An invalid access sets `rsp_err` for exactly one cycle, returns read data zero, and changes no register.
- R12: A synchronous active-high reset clears every register to zero except the TOC register. Read data and the error flag are registered and appear one cycle after the request. Writes return read data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe, one access per cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data |
| irq_lines | input | IRQ_W | Interrupt source levels |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Registered invalid-access pulse |
| win_fwd_en | output | 30 | Forward enables for windows 1 to 30 |
| cfg_addr_o | output | 32 | Configuration address, bits 1:0 cleared |
| fb2b_en_o | output | 2 | Fast back-to-back enables |
| toc_addr_o | output | 32 | TOC target address |

## Verification
The bench builds the bank with ADDR_W = 10 and IRQ_W = 6. With a 1 KiB address space, every word address can be swept and its valid/error outcome compared with the map. This catches off-by-one errors at the end of the feature block and any alias left from partial decoding. The six interrupt lines keep the level/mask/control products small enough to set bit patterns by hand. Each feature register is driven with all-ones, alternating and zero patterns, and the expected read-back is computed from its width and read-zero mask. The data window is tried at each offset with each size code.

// File: rtl/pcib_csr_pkg.sv
package pcib_csr_pkg;

  localparam int FEAT_N   = 13;
  localparam int NUM_WIN  = 30;

  localparam int unsigned A_IO_EN  = 32'h000;
  localparam int unsigned A_IO_CTL = 32'h004;
  localparam int unsigned A_FB2B   = 32'h008;
  localparam int unsigned A_TOC    = 32'h00C;
  localparam int unsigned A_CFG    = 32'h010;
  localparam int unsigned A_IPEND  = 32'h014;
  localparam int unsigned A_IMASK  = 32'h018;
  localparam int unsigned A_ICTL   = 32'h01C;
  localparam int unsigned A_ILVL   = 32'h020;
  localparam int unsigned A_IREQ0  = 32'h024;
  localparam int unsigned A_IREQ1  = 32'h028;
  localparam int unsigned A_IODAT  = 32'h040;
  localparam int unsigned A_FEAT   = 32'h100;

  localparam logic [31:0] TOC_FIXED = 32'hFFFA0030;
  localparam logic [31:0] TOC_WMASK = 32'h0001E000;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_IO_EN, SEL_IO_CTL, SEL_FB2B, SEL_TOC, SEL_CFG,
    SEL_IPEND, SEL_IMASK, SEL_ICTL, SEL_ILVL, SEL_IREQ0, SEL_IREQ1,
    SEL_IODAT, SEL_FEAT
  } sel_e;

  function automatic int unsigned feat_width(input int idx);
    case (idx)
      0:       return 1;
      1, 2, 4: return 7;
      3, 7:    return 8;
      5, 12:   return 9;
      8:       return 30;
      9:       return 24;
      10:      return 22;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] feat_wmask(input int idx);
    logic [63:0] m;
    m = (64'd1 << feat_width(idx)) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] feat_rzero(input int idx);
    case (idx)
      1:       return 32'h0000_0001;
      7:       return 32'h0000_0007;
      8:       return 32'h0107_10E8;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/pcib_csr_decode.sv
module pcib_csr_decode
  import pcib_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(FEAT_N)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              ok,
  output sel_e              sel,
  output logic [IDX_W-1:0]  feat_idx
);

  logic [31:0] ai;
  logic [31:0] foff;

  always_comb begin
    ai       = 32'(addr);
    foff     = ai - A_FEAT;
    ok       = 1'b0;
    sel      = SEL_NONE;
    feat_idx = '0;
    if (ai[1:0] == 2'b00) begin
      ok = 1'b1;
      case (ai)
        A_IO_EN:  sel = SEL_IO_EN;
        A_IO_CTL: sel = SEL_IO_CTL;
        A_FB2B:   sel = SEL_FB2B;
        A_TOC:    sel = SEL_TOC;
        A_CFG:    sel = SEL_CFG;
        A_IPEND:  sel = SEL_IPEND;
        A_IMASK:  sel = SEL_IMASK;
        A_ICTL:   sel = SEL_ICTL;
        A_ILVL:   sel = SEL_ILVL;
        A_IREQ0:  sel = SEL_IREQ0;
        A_IREQ1:  sel = SEL_IREQ1;
        default:  ok  = 1'b0;
      endcase
      // inclusive of the last feature register (index FEAT_N-1)
      if (ai >= A_FEAT && foff < 32'(4 * FEAT_N)) begin
        ok       = 1'b1;
        sel      = SEL_FEAT;
        feat_idx = IDX_W'(foff >> 2);
      end
    end
    if (ai[31:2] == A_IODAT[31:2]) begin
      sel = SEL_IODAT;
      case (ai[1:0])
        2'd0:    ok = 1'b1;
        2'd2:    ok = (size == SZ_BYTE) || (size == SZ_HALF);
        default: ok = (size == SZ_BYTE);
      endcase
    end
  end

endmodule

// File: rtl/pcib_feat_bank.sv
module pcib_feat_bank
  import pcib_csr_pkg::*;
#(
  localparam int IDX_W = $clog2(FEAT_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data
);

  logic [31:0] regs [FEAT_N];
  logic [31:0] view [FEAT_N];

  for (genvar g = 0; g < FEAT_N; g++) begin : g_reg
    localparam logic [31:0] WMASK = feat_wmask(g);
    localparam logic [31:0] RZERO = feat_rzero(g);
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (wr_en && idx == IDX_W'(g))
        regs[g] <= wr_data & WMASK;
    end
    assign view[g] = regs[g] & ~RZERO;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < FEAT_N; i++)
      if (idx == IDX_W'(i)) rd_data = view[i];
  end

endmodule

// File: rtl/pcib_win_fwd.sv
module pcib_win_fwd
  import pcib_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_WIN:1]   win_en,
  input  logic [1:0]         fwd_mode,
  output logic [NUM_WIN-1:0] win_fwd
);

  logic mode_on;
  assign mode_on = (fwd_mode == 2'b01);

  for (genvar k = 1; k <= NUM_WIN; k++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) win_fwd[k-1] <= 1'b0;
      else     win_fwd[k-1] <= mode_on & win_en[k];
    end
  end

  AST_FWD_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    (|win_fwd) |-> ($past(fwd_mode) == 2'b01)); // R9

endmodule

// File: rtl/pcib_csr_bank.sv
module pcib_csr_bank
  import pcib_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IRQ_W  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_wdata,
  input  logic [IRQ_W-1:0]   irq_lines,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic [NUM_WIN-1:0] win_fwd_en,
  output logic [31:0]        cfg_addr_o,
  output logic [1:0]         fb2b_en_o,
  output logic [31:0]        toc_addr_o
);

  localparam int IDX_W = $clog2(FEAT_N);

  logic             dec_ok;
  sel_e             dec_sel;
  logic [IDX_W-1:0] dec_idx;
  logic             acc, wr, rd;
  logic [31:0]      feat_rd;
  logic [31:0]      rd_mux;

  logic [31:0]      io_en_q, io_ctl_q, toc_q, cfg_q;
  logic [1:0]       fb2b_q;
  logic [IRQ_W-1:0] ipend_q, imask_q, ictl_q, ilvl_q;

  pcib_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (req_addr),
    .size     (req_size),
    .ok       (dec_ok),
    .sel      (dec_sel),
    .feat_idx (dec_idx)
  );

  assign acc = req_valid && dec_ok;
  assign wr  = acc && req_we;
  assign rd  = acc && !req_we;

  pcib_feat_bank u_feat (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr && dec_sel == SEL_FEAT),
    .idx     (dec_idx),
    .wr_data (req_wdata),
    .rd_data (feat_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_en_q  <= '0;
      io_ctl_q <= '0;
      fb2b_q   <= '0;
      toc_q    <= TOC_FIXED;
      cfg_q    <= '0;
      imask_q  <= '0;
      ictl_q   <= '0;
    end else if (wr) begin
      case (dec_sel)
        SEL_IO_EN:  io_en_q  <= req_wdata;
        SEL_IO_CTL: io_ctl_q <= req_wdata;
        SEL_FB2B:   fb2b_q   <= req_wdata[1:0];
        SEL_TOC:    toc_q    <= TOC_FIXED | (req_wdata & TOC_WMASK);
        SEL_CFG:    cfg_q    <= req_wdata;
        SEL_IMASK:  imask_q  <= req_wdata[IRQ_W-1:0];
        SEL_ICTL:   ictl_q   <= req_wdata[IRQ_W-1:0];
        default:    ;
      endcase
    end
  end

  // interrupt level sampling and pending accumulation
  always_ff @(posedge clk) begin
    if (rst) begin
      ilvl_q  <= '0;
      ipend_q <= '0;
    end else begin
      ilvl_q <= irq_lines;
      if (wr && dec_sel == SEL_IPEND) ipend_q <= '0;
      else                            ipend_q <= ipend_q | ilvl_q;
    end
  end

  always_comb begin
    case (dec_sel)
      SEL_IO_EN:  rd_mux = io_en_q;
      SEL_IO_CTL: rd_mux = io_ctl_q;
      SEL_FB2B:   rd_mux = 32'(fb2b_q);
      SEL_TOC:    rd_mux = toc_q;
      SEL_CFG:    rd_mux = cfg_q;
      SEL_IPEND:  rd_mux = 32'(ipend_q);
      SEL_IMASK:  rd_mux = 32'(imask_q);
      SEL_ICTL:   rd_mux = 32'(ictl_q);
      SEL_ILVL:   rd_mux = 32'(ilvl_q);
      SEL_IREQ0:  rd_mux = 32'(ipend_q & imask_q);
      SEL_IREQ1:  rd_mux = 32'(ilvl_q & imask_q & ictl_q);
      SEL_FEAT:   rd_mux = feat_rd;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= rd ? rd_mux : '0;
      rsp_err   <= req_valid && !dec_ok;
    end
  end

  pcib_win_fwd u_win (
    .clk      (clk),
    .rst      (rst),
    .win_en   (io_en_q[NUM_WIN:1]),
    .fwd_mode (io_ctl_q[8:7]),
    .win_fwd  (win_fwd_en)
  );

  assign cfg_addr_o = {cfg_q[31:2], 2'b00};
  assign fb2b_en_o  = fb2b_q;
  assign toc_addr_o = toc_q;

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == 32'h0)); // R11

  AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(req_valid)); // R11

  AST_BAD_WRITE_KEEPS_TOC: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && !dec_ok) |=> (toc_q == $past(toc_q))); // R11

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (wr && dec_sel == SEL_IPEND) |=> (ipend_q == '0)); // R6

  AST_FEAT8_RZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && dec_sel == SEL_FEAT && dec_idx == IDX_W'(8))
      |=> ((rsp_rdata & 32'h0107_10E8) == 32'h0)); // R3

endmodule

// File: tb/pcib_csr_bank_bench.sv
`timescale 1ns/1ps
module pcib_csr_bank_bench;

  localparam int AW = 10;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd2;
  logic [31:0]   req_wdata = '0;
  logic [IW-1:0] irq_lines = '0;
  logic [31:0]   rsp_rdata;
  logic          rsp_err;
  logic [29:0]   win_fwd_en;
  logic [31:0]   cfg_addr_o;
  logic [1:0]    fb2b_en_o;
  logic [31:0]   toc_addr_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pcib_csr_bank #(.ADDR_W(AW), .IRQ_W(IW)) u_pcib_csr_bank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .irq_lines(irq_lines), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .win_fwd_en(win_fwd_en), .cfg_addr_o(cfg_addr_o),
    .fb2b_en_o(fb2b_en_o), .toc_addr_o(toc_addr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input int addr, input logic [1:0] sz,
                        input logic [31:0] data,
                        output logic [31:0] rdat, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = AW'(addr);
    req_size = sz; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    rdat = rsp_rdata; err = rsp_err;
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    logic [31:0] d; logic e;
    access(1'b1, addr, 2'd2, data, d, e);
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    logic e;
    access(1'b0, addr, 2'd2, 32'h0, data, e);
  endtask

  function automatic int fwidth(input int i);
    int w [13] = '{1, 7, 7, 8, 7, 9, 0, 8, 30, 24, 22, 0, 9};
    return w[i];
  endfunction

  function automatic logic [31:0] fexp(input int i, input logic [31:0] v);
    logic [63:0] m;
    logic [31:0] z;
    m = (64'd1 << fwidth(i)) - 64'd1;
    z = (i == 1) ? 32'h1 : (i == 7) ? 32'h7 : (i == 8) ? 32'h010710E8 : 32'h0;
    return v & m[31:0] & ~z;
  endfunction

  function automatic bit addr_ok(input int a);
    if (a >= 'h100 && a <= 'h130) return 1;
    if (a <= 'h028) return 1;
    if (a == 'h040) return 1;
    return 0;
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic e;
    logic [31:0] pats [3] = '{32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0};

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk("R12 err after reset", 32'(rsp_err), 32'h0);
    chk("R12 win after reset", 32'(win_fwd_en), 32'h0);
    chk("R5 toc reset", toc_addr_o, 32'hFFFA0030);
    chk("R12 cfg reset", cfg_addr_o, 32'h0);
    for (int i = 0; i < 13; i++) begin
      rd('h100 + 4 * i, d);
      chk("R12 feature reset", d, 32'h0);
    end

    // R1 R10 R11 sweep of every word address with word size
    for (int a = 0; a < (1 << AW); a += 4) begin
      access(1'b0, a, 2'd2, 32'h0, d, e);
      chk($sformatf("R1 valid @%h", a), 32'(e), 32'(!addr_ok(a)));
      if (e) chk("R11 invalid read data", d, 32'h0);
    end
    @(negedge clk);
    chk("R11 err is one pulse", 32'(rsp_err), 32'h0);

    // R10 data window offsets x sizes
    for (int off = 0; off < 4; off++)
      for (int s = 0; s < 4; s++) begin
        bit okx;
        okx = (off == 0) || (off == 2 && s <= 1) || (s == 0);
        access(1'b0, 'h40 + off, 2'(s), 32'h0, d, e);
        chk($sformatf("R10 iodat off%0d size%0d", off, s), 32'(e), 32'(!okx));
        chk("R10 iodat read zero", d, 32'h0);
      end
    access(1'b0, 'h102, 2'd0, 32'h0, d, e);
    chk("R1 unaligned reg offset", 32'(e), 32'h1);

    // R2 R3 feature masks
    foreach (pats[p])
      for (int i = 0; i < 13; i++) begin
        wr('h100 + 4 * i, pats[p]);
        rd('h100 + 4 * i, d);
        chk($sformatf("R2 R3 feature %0d", i), d, fexp(i, pats[p]));
      end

    // R11 invalid write leaves state unchanged
    wr('h108, 32'h0000_005A);
    wr('h130, 32'h0000_0123);
    access(1'b1, 'h134, 2'd2, 32'hFFFF_FFFF, d, e);
    chk("R11 bad write err", 32'(e), 32'h1);
    chk("R11 bad write data", d, 32'h0);
    access(1'b1, 'h0C1, 2'd2, 32'hFFFF_FFFF, d, e);
    rd('h130, d);
    chk("R11 last feature kept", d, 32'h123);
    rd('h108, d);
    chk("R11 feature 2 kept", d, 32'h5A);
    chk("R11 toc kept", toc_addr_o, 32'hFFFA0030);
    access(1'b1, 'h042, 2'd2, 32'hFFFF_FFFF, d, e);
    chk("R10 bad size write err", 32'(e), 32'h1);

    // R4 fast back-to-back
    wr('h008, 32'hFFFF_FFFE);
    rd('h008, d);
    chk("R4 fb2b read", d, 32'h2);
    chk("R4 fb2b port", 32'(fb2b_en_o), 32'h2);

    // R5 TOC
    wr('h00C, 32'hFFFF_FFFF);
    rd('h00C, d);
    chk("R5 toc all ones", d, 32'hFFFBE030);
    wr('h00C, 32'h0000_2000);
    chk("R5 toc port", toc_addr_o, 32'hFFFA2030);

    // R8 config address
    wr('h010, 32'h8000_1237);
    rd('h010, d);
    chk("R8 cfg readback", d, 32'h8000_1237);
    chk("R8 cfg forwarded", cfg_addr_o, 32'h8000_1234);

    // R6 R7 interrupts
    irq_lines = 6'b101101;
    repeat (3) @(negedge clk);
    irq_lines = 6'b000101;
    repeat (2) @(negedge clk);
    wr('h018, 32'h0000_003C);
    wr('h01C, 32'h0000_0017);
    rd('h020, d);
    chk("R6 level", d, 32'h05);
    rd('h014, d);
    chk("R6 pending accumulates", d, 32'h2D);
    rd('h024, d);
    chk("R7 irq req 0", d, 32'h2D & 32'h3C);
    rd('h028, d);
    chk("R7 irq req 1", d, 32'h05 & 32'h3C & 32'h17);
    wr('h020, 32'hFFFF_FFFF);
    wr('h028, 32'hFFFF_FFFF);
    rd('h020, d);
    chk("R6 level ignores write", d, 32'h05);
    irq_lines = '0;
    repeat (2) @(negedge clk);
    wr('h014, 32'h1234_5678);
    rd('h014, d);
    chk("R6 pending cleared", d, 32'h0);

    // R9 window forwarding
    wr('h000, 32'hFFFF_FFFF);
    wr('h004, 32'h0);
    @(negedge clk);
    chk("R9 mode 00 blocks", 32'(win_fwd_en), 32'h0);
    rd('h000, d);
    chk("R9 enable stores 32 bits", d, 32'hFFFF_FFFF);
    wr('h004, 32'h0000_0080);
    @(negedge clk);
    chk("R9 mode 01 all", 32'(win_fwd_en), 32'h3FFF_FFFF);
    wr('h004, 32'h0000_0180);
    @(negedge clk);
    chk("R9 mode 11 blocks", 32'(win_fwd_en), 32'h0);
    wr('h004, 32'h0000_0080);
    wr('h000, 32'h8000_0001);
    @(negedge clk);
    chk("R9 edge windows excluded", 32'(win_fwd_en), 32'h0);
    wr('h000, 32'h4000_0002);
    @(negedge clk);
    chk("R9 windows 1 and 30", 32'(win_fwd_en), 32'h2000_0001);

    finish_run();
  end

endmodule